// File: doc/BRIEF.md
# Radix-4 Complex Butterfly Unit

This block is one pipelined radix-4 butterfly for a fixed-point FFT whose length is a power of four (16, 64, 256, 1024 points). Each accepted word carries four signed 16-bit complex samples and three complex twiddle factors from an external sine/cosine table. The unit forms the pairwise sums and differences and combines them into four legs. The rotation by -j is done by swapping the real and imaginary parts and negating one of them, so it needs no multiplier. Legs 1 to 3 are then multiplied by their twiddles. All four results leave as saturated signed 16-bit complex values.

Two build-time parameters set the accuracy and the gain. `TW_W` selects 12-bit twiddles (Q1.11) or 8-bit twiddles (Q1.7). Each full-width product is shifted right arithmetically by `TW_W-1`. `HALVE` enables a divide-by-two on the first sum/difference level. This limits the growth of the transform's gain when the input is wider than 10 bits or the length is above 64. Address generation, twiddle storage and stage sequencing belong to the surrounding FFT engine.

Top module: `r4bf_core`

## Requirements
- R1: `out_valid` equals `in_valid` from three clock edges earlier, so the latency is fixed at 3 cycles.
- R2: While `rst` is high at a rising edge, `out_valid` and every `y*` output become 0, whatever `in_valid` and the data inputs carry.
- R3: The first level forms s0=a0+a2, d0=a0-a2, s1=a1+a3 and d1=a1-a3. Output y0 is sat(s0+s1), computed per component and applied without a twiddle.
- R4: Output y2 is the twiddle product (R6) of x2=s0-s1 with twiddle 2.
- R5: Output y1 is the twiddle product of x1=d0-j*d1, where re = d0.re+d1.im and im = d0.im-d1.re, with twiddle 1. Output y3 is the twiddle product of x3=d0+j*d1, where re = d0.re-d1.im and im = d0.im+d1.re, with twiddle 3.
- R6: Twiddles are signed two's-complement values of `TW_W` bits (12 or 8) with F=`TW_W-1` fraction bits. The product of x with w gives re=(x.re*w.re - x.im*w.im)>>>F and im=(x.re*w.im + x.im*w.re)>>>F. The shifts are arithmetic, so they round toward minus infinity, and the products are formed at full width.
- R7: With `HALVE`=1, each of s0, d0, s1 and d1 is shifted right arithmetically by one before the second level. With `HALVE`=0 no shift is applied.
- R8: Every output component saturates to the range -32768 to 32767.
- R9: When no valid word reaches the output stage, all `y*` outputs keep their previous values.
- R10: A new word can be accepted on every cycle, and each result appears exactly three cycles after its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| a0_re | input | 16 | Sample 0 real |
| a0_im | input | 16 | Sample 0 imaginary |
| a1_re | input | 16 | Sample 1 real |
| a1_im | input | 16 | Sample 1 imaginary |
| a2_re | input | 16 | Sample 2 real |
| a2_im | input | 16 | Sample 2 imaginary |
| a3_re | input | 16 | Sample 3 real |
| a3_im | input | 16 | Sample 3 imaginary |
| w1_re | input | TW_W | Twiddle 1 real (cosine) |
| w1_im | input | TW_W | Twiddle 1 imaginary (sine) |
| w2_re | input | TW_W | Twiddle 2 real |
| w2_im | input | TW_W | Twiddle 2 imaginary |
| w3_re | input | TW_W | Twiddle 3 real |
| w3_im | input | TW_W | Twiddle 3 imaginary |
| out_valid | output | 1 | Result word present |
| y0_re | output | 16 | Leg 0 real |
| y0_im | output | 16 | Leg 0 imaginary |
| y1_re | output | 16 | Leg 1 real |
| y1_im | output | 16 | Leg 1 imaginary |
| y2_re | output | 16 | Leg 2 real |
| y2_im | output | 16 | Leg 2 imaginary |
| y3_re | output | 16 | Leg 3 real |
| y3_im | output | 16 | Leg 3 imaginary |

## Verification
The assertions assume that `rst` is held high for at least one edge before any traffic and that `in_valid` always has a known level. The latency and hold properties are meaningful only under these conditions. The range property on the halved first level relies on the inputs being true 16-bit values, which the port width guarantees. The stimulus changes every input on the falling edge only and keeps reset asserted for several cycles at start-up. It derives each 8-bit twiddle from its 12-bit counterpart by an arithmetic shift, so both twiddle formats stay inside their representable ranges, including the most negative value.

// File: rtl/r4bf_pkg.sv
package r4bf_pkg;

    // Sample width: sign plus 15 magnitude bits
    localparam int DW    = 16;
    // Internal width after two add levels (growth of 2 bits plus margin)
    localparam int WW    = DW + 3;
    // Width used when handing results to the saturator
    localparam int ACC_W = 40;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [WW-1:0] re;
        logic signed [WW-1:0] im;
    } wide_t;

    typedef enum logic {
        GAIN_FULL = 1'b0,
        GAIN_HALF = 1'b1
    } gain_mode_e;

    function automatic wide_t widen(input cplx_t c);
        wide_t r;
        r.re = {{(WW-DW){c.re[DW-1]}}, c.re};
        r.im = {{(WW-DW){c.im[DW-1]}}, c.im};
        return r;
    endfunction

    function automatic logic signed [WW-1:0] scale_lvl(
        input logic signed [WW-1:0] v,
        input gain_mode_e           mode
    );
        return (mode == GAIN_HALF) ? (v >>> 1) : v;
    endfunction

    function automatic logic signed [DW-1:0] sat_dw(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};
        if (v > hi)
            return {1'b0, {(DW-1){1'b1}}};
        else if (v < lo)
            return {1'b1, {(DW-1){1'b0}}};
        else
            return v[DW-1:0];
    endfunction

endpackage

// File: rtl/r4bf_addsub.sv
module r4bf_addsub
    import r4bf_pkg::*;
#(
    parameter bit HALVE = 1'b0
) (
    input  cplx_t a,
    input  cplx_t b,
    output wide_t sum,
    output wide_t dif
);
    localparam gain_mode_e MODE = HALVE ? GAIN_HALF : GAIN_FULL;

    wide_t wa;
    wide_t wb;
    wide_t s_raw;
    wide_t d_raw;

    always_comb begin
        wa       = widen(a);
        wb       = widen(b);
        s_raw.re = wa.re + wb.re;
        s_raw.im = wa.im + wb.im;
        d_raw.re = wa.re - wb.re;
        d_raw.im = wa.im - wb.im;
        sum.re   = scale_lvl(s_raw.re, MODE);
        sum.im   = scale_lvl(s_raw.im, MODE);
        dif.re   = scale_lvl(d_raw.re, MODE);
        dif.im   = scale_lvl(d_raw.im, MODE);
    end

endmodule

// File: rtl/r4bf_combine.sv
module r4bf_combine
    import r4bf_pkg::*;
(
    input  wide_t s0,
    input  wide_t d0,
    input  wide_t s1,
    input  wide_t d1,
    output wide_t x0,
    output wide_t x1,
    output wide_t x2,
    output wide_t x3
);
    always_comb begin
        // Leg 0 and leg 2 from the sums
        x0.re = s0.re + s1.re;
        x0.im = s0.im + s1.im;
        x2.re = s0.re - s1.re;
        x2.im = s0.im - s1.im;
        // Leg 1: d0 rotated by -j on d1 (swap and negate, no multiplier)
        x1.re = d0.re + d1.im;
        x1.im = d0.im - d1.re;
        // Leg 3: d0 rotated by +j on d1
        x3.re = d0.re - d1.im;
        x3.im = d0.im + d1.re;
    end

endmodule

// File: rtl/r4bf_twmul.sv
module r4bf_twmul
    import r4bf_pkg::*;
#(
    parameter int TW_W = 12
) (
    input  wide_t                  x,
    input  logic signed [TW_W-1:0] w_re,
    input  logic signed [TW_W-1:0] w_im,
    output cplx_t                  y
);
    localparam int FRAC = TW_W - 1;
    localparam int PW   = WW + TW_W + 1;

    logic signed [PW-1:0]    p_re;
    logic signed [PW-1:0]    p_im;
    logic signed [PW-1:0]    q_re;
    logic signed [PW-1:0]    q_im;
    logic signed [ACC_W-1:0] acc_re;
    logic signed [ACC_W-1:0] acc_im;

    always_comb begin
        p_re   = PW'($signed(x.re)) * PW'($signed(w_re))
               - PW'($signed(x.im)) * PW'($signed(w_im));
        p_im   = PW'($signed(x.re)) * PW'($signed(w_im))
               + PW'($signed(x.im)) * PW'($signed(w_re));
        q_re   = p_re >>> FRAC;
        q_im   = p_im >>> FRAC;
        acc_re = ACC_W'(q_re);
        acc_im = ACC_W'(q_im);
        y.re   = sat_dw(acc_re);
        y.im   = sat_dw(acc_im);
    end

endmodule

// File: rtl/r4bf_core.sv
module r4bf_core
    import r4bf_pkg::*;
#(
    parameter int TW_W  = 12,
    parameter bit HALVE = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   a0_re,
    input  logic signed [DW-1:0]   a0_im,
    input  logic signed [DW-1:0]   a1_re,
    input  logic signed [DW-1:0]   a1_im,
    input  logic signed [DW-1:0]   a2_re,
    input  logic signed [DW-1:0]   a2_im,
    input  logic signed [DW-1:0]   a3_re,
    input  logic signed [DW-1:0]   a3_im,
    input  logic signed [TW_W-1:0] w1_re,
    input  logic signed [TW_W-1:0] w1_im,
    input  logic signed [TW_W-1:0] w2_re,
    input  logic signed [TW_W-1:0] w2_im,
    input  logic signed [TW_W-1:0] w3_re,
    input  logic signed [TW_W-1:0] w3_im,
    output logic                   out_valid,
    output logic signed [DW-1:0]   y0_re,
    output logic signed [DW-1:0]   y0_im,
    output logic signed [DW-1:0]   y1_re,
    output logic signed [DW-1:0]   y1_im,
    output logic signed [DW-1:0]   y2_re,
    output logic signed [DW-1:0]   y2_im,
    output logic signed [DW-1:0]   y3_re,
    output logic signed [DW-1:0]   y3_im
);
    localparam int NLEG = 4;
    localparam int NTW  = NLEG - 1;
    localparam int NPR  = NLEG / 2;

    typedef struct packed {
        logic signed [TW_W-1:0] re;
        logic signed [TW_W-1:0] im;
    } tw_t;

    // ---------------- input unpacking ----------------
    cplx_t a_in  [NLEG];
    tw_t   tw_in [NTW];

    assign a_in[0]  = {a0_re, a0_im};
    assign a_in[1]  = {a1_re, a1_im};
    assign a_in[2]  = {a2_re, a2_im};
    assign a_in[3]  = {a3_re, a3_im};
    assign tw_in[0] = {w1_re, w1_im};
    assign tw_in[1] = {w2_re, w2_im};
    assign tw_in[2] = {w3_re, w3_im};

    // ---------------- stage 1: sum / difference ----------------
    wide_t sum_c [NPR];
    wide_t dif_c [NPR];

    for (genvar g = 0; g < NPR; g++) begin : g_lvl1
        r4bf_addsub #(.HALVE(HALVE)) u_as (
            .a   (a_in[g]),
            .b   (a_in[g+NPR]),
            .sum (sum_c[g]),
            .dif (dif_c[g])
        );
    end

    logic  v1;
    wide_t s0_q, d0_q, s1_q, d1_q;
    tw_t   tw_q1 [NTW];

    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            s0_q <= '0;
            d0_q <= '0;
            s1_q <= '0;
            d1_q <= '0;
            for (int i = 0; i < NTW; i++) tw_q1[i] <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                s0_q  <= sum_c[0];
                d0_q  <= dif_c[0];
                s1_q  <= sum_c[1];
                d1_q  <= dif_c[1];
                tw_q1 <= tw_in;
            end
        end
    end

    // ---------------- stage 2: leg combination ----------------
    wide_t x_c [NLEG];

    r4bf_combine u_comb (
        .s0 (s0_q),
        .d0 (d0_q),
        .s1 (s1_q),
        .d1 (d1_q),
        .x0 (x_c[0]),
        .x1 (x_c[1]),
        .x2 (x_c[2]),
        .x3 (x_c[3])
    );

    logic  v2;
    wide_t x_q   [NLEG];
    tw_t   tw_q2 [NTW];

    always_ff @(posedge clk) begin
        if (rst) begin
            v2 <= 1'b0;
            for (int i = 0; i < NLEG; i++) x_q[i]   <= '0;
            for (int i = 0; i < NTW;  i++) tw_q2[i] <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                x_q   <= x_c;
                tw_q2 <= tw_q1;
            end
        end
    end

    // ---------------- stage 3: twiddle multiply and saturate ----------------
    cplx_t y_c [NLEG];

    assign y_c[0].re = sat_dw(ACC_W'($signed(x_q[0].re)));
    assign y_c[0].im = sat_dw(ACC_W'($signed(x_q[0].im)));

    for (genvar g = 1; g < NLEG; g++) begin : g_tw
        r4bf_twmul #(.TW_W(TW_W)) u_tm (
            .x    (x_q[g]),
            .w_re (tw_q2[g-1].re),
            .w_im (tw_q2[g-1].im),
            .y    (y_c[g])
        );
    end

    logic  vout;
    cplx_t y_q [NLEG];

    always_ff @(posedge clk) begin
        if (rst) begin
            vout <= 1'b0;
            for (int i = 0; i < NLEG; i++) y_q[i] <= '0;
        end else begin
            vout <= v2;
            if (v2) y_q <= y_c;
        end
    end

    assign out_valid = vout;
    assign y0_re = y_q[0].re;
    assign y0_im = y_q[0].im;
    assign y1_re = y_q[1].re;
    assign y1_im = y_q[1].im;
    assign y2_re = y_q[2].re;
    assign y2_im = y_q[2].im;
    assign y3_re = y_q[3].re;
    assign y3_im = y_q[3].im;

    // ---------------- assertions ----------------
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !v2 |=> $stable({y0_re, y0_im, y1_re, y1_im, y2_re, y2_im, y3_re, y3_im})); // R9

    AST_ZERO_LEG: assert property (@(posedge clk) disable iff (rst)
        (v2 && x_q[1] == '0) |=> (y1_re == '0 && y1_im == '0)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (v2 && !x_q[0].re[WW-1] && x_q[0].re[WW-2:DW-1] != '0)
        |=> (y0_re == {1'b0, {(DW-1){1'b1}}})); // R8

    if (HALVE) begin : g_half_chk
        AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst)
            v1 |-> (((s0_q.re[WW-1:DW-1] == '0) || (s0_q.re[WW-1:DW-1] == '1)) &&
                    ((d1_q.im[WW-1:DW-1] == '0) || (d1_q.im[WW-1:DW-1] == '1)))); // R7
    end

endmodule

// File: tb/r4bf_core_test.sv
module r4bf_core_test;
    import r4bf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] a0_re = '0, a0_im = '0, a1_re = '0, a1_im = '0;
    logic signed [15:0] a2_re = '0, a2_im = '0, a3_re = '0, a3_im = '0;
    logic signed [11:0] w1_re = '0, w1_im = '0, w2_re = '0, w2_im = '0, w3_re = '0, w3_im = '0;
    logic signed [7:0]  h_w1_re = '0, h_w1_im = '0, h_w2_re = '0, h_w2_im = '0, h_w3_re = '0, h_w3_im = '0;
    logic out_valid, h_out_valid;
    logic signed [15:0] y0_re, y0_im, y1_re, y1_im, y2_re, y2_im, y3_re, y3_im;
    logic signed [15:0] h_y0_re, h_y0_im, h_y1_re, h_y1_im, h_y2_re, h_y2_im, h_y3_re, h_y3_im;

    int total = 0;
    int bad   = 0;
    int vr [8][4];
    int vi [8][4];
    int wr [8][3];
    int wi [8][3];

    always #5 clk = ~clk;

    r4bf_core #(.TW_W(12), .HALVE(1'b0)) uut (.*);

    r4bf_core #(.TW_W(8), .HALVE(1'b1)) uut_h (
        .*,
        .w1_re(h_w1_re), .w1_im(h_w1_im), .w2_re(h_w2_re), .w2_im(h_w2_im),
        .w3_re(h_w3_re), .w3_im(h_w3_im), .out_valid(h_out_valid),
        .y0_re(h_y0_re), .y0_im(h_y0_im), .y1_re(h_y1_re), .y1_im(h_y1_im),
        .y2_re(h_y2_re), .y2_im(h_y2_im), .y3_re(h_y3_re), .y3_im(h_y3_im)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Reference computed from R3..R7
    task automatic model(input int k, input bit hv, input int frac,
                         output int er[4], output int ei[4]);
        int s0r, s0i, d0r, d0i, s1r, s1i, d1r, d1i;
        int xr[4], xi[4], tr, ti;
        s0r = vr[k][0] + vr[k][2]; s0i = vi[k][0] + vi[k][2];
        d0r = vr[k][0] - vr[k][2]; d0i = vi[k][0] - vi[k][2];
        s1r = vr[k][1] + vr[k][3]; s1i = vi[k][1] + vi[k][3];
        d1r = vr[k][1] - vr[k][3]; d1i = vi[k][1] - vi[k][3];
        if (hv) begin
            s0r = s0r >>> 1; s0i = s0i >>> 1; d0r = d0r >>> 1; d0i = d0i >>> 1;
            s1r = s1r >>> 1; s1i = s1i >>> 1; d1r = d1r >>> 1; d1i = d1i >>> 1;
        end
        xr[0] = s0r + s1r;  xi[0] = s0i + s1i;
        xr[2] = s0r - s1r;  xi[2] = s0i - s1i;
        xr[1] = d0r + d1i;  xi[1] = d0i - d1r;
        xr[3] = d0r - d1i;  xi[3] = d0i + d1r;
        er[0] = sat16(xr[0]);
        ei[0] = sat16(xi[0]);
        for (int j = 1; j < 4; j++) begin
            tr = (frac == 11) ? wr[k][j-1] : (wr[k][j-1] >>> 4);
            ti = (frac == 11) ? wi[k][j-1] : (wi[k][j-1] >>> 4);
            er[j] = sat16((xr[j] * tr - xi[j] * ti) >>> frac);
            ei[j] = sat16((xr[j] * ti + xi[j] * tr) >>> frac);
        end
    endtask

    function automatic int get_y(input bit h, input int j, input bit im);
        case ({h, 2'(j), im})
            4'b0000: return int'(y0_re);   4'b0001: return int'(y0_im);
            4'b0010: return int'(y1_re);   4'b0011: return int'(y1_im);
            4'b0100: return int'(y2_re);   4'b0101: return int'(y2_im);
            4'b0110: return int'(y3_re);   4'b0111: return int'(y3_im);
            4'b1000: return int'(h_y0_re); 4'b1001: return int'(h_y0_im);
            4'b1010: return int'(h_y1_re); 4'b1011: return int'(h_y1_im);
            4'b1100: return int'(h_y2_re); 4'b1101: return int'(h_y2_im);
            4'b1110: return int'(h_y3_re); default: return int'(h_y3_im);
        endcase
    endfunction

    task automatic drive(input int k);
        in_valid = 1'b1;
        a0_re = 16'(vr[k][0]); a0_im = 16'(vi[k][0]);
        a1_re = 16'(vr[k][1]); a1_im = 16'(vi[k][1]);
        a2_re = 16'(vr[k][2]); a2_im = 16'(vi[k][2]);
        a3_re = 16'(vr[k][3]); a3_im = 16'(vi[k][3]);
        w1_re = 12'(wr[k][0]); w1_im = 12'(wi[k][0]);
        w2_re = 12'(wr[k][1]); w2_im = 12'(wi[k][1]);
        w3_re = 12'(wr[k][2]); w3_im = 12'(wi[k][2]);
        h_w1_re = 8'(wr[k][0] >>> 4); h_w1_im = 8'(wi[k][0] >>> 4);
        h_w2_re = 8'(wr[k][1] >>> 4); h_w2_im = 8'(wi[k][1] >>> 4);
        h_w3_re = 8'(wr[k][2] >>> 4); h_w3_im = 8'(wi[k][2] >>> 4);
    endtask

    task automatic set_all(input int k, input int ar, input int ai, input int tr, input int ti);
        for (int j = 0; j < 4; j++) begin vr[k][j] = ar; vi[k][j] = ai; end
        for (int j = 0; j < 3; j++) begin wr[k][j] = tr; wi[k][j] = ti; end
    endtask

    task automatic check_vec(input string scen, input int k);
        int er[4], ei[4], hr[4], hi[4];
        string t;
        model(k, 1'b0, 11, er, ei);
        model(k, 1'b1, 7, hr, hi);
        for (int j = 0; j < 4; j++) begin
            t = (j == 0) ? "R3" : (j == 2) ? "R4" : "R5";
            chk($sformatf("%s %s y%0d re", scen, t, j), get_y(1'b0, j, 1'b0), er[j]);
            chk($sformatf("%s %s y%0d im", scen, t, j), get_y(1'b0, j, 1'b1), ei[j]);
            chk($sformatf("%s R7 halved y%0d re", scen, j), get_y(1'b1, j, 1'b0), hr[j]);
            chk($sformatf("%s R7 halved y%0d im", scen, j), get_y(1'b1, j, 1'b1), hi[j]);
        end
    endtask

    // Drive n words back to back; each result is sampled three falling edges later
    task automatic run_burst(input string scen, input int n);
        for (int c = 0; c < n + 3; c++) begin
            @(negedge clk);
            chk($sformatf("%s R1 out_valid", scen), int'(out_valid), (c >= 3) ? 1 : 0);
            chk($sformatf("%s R1 halved out_valid", scen), int'(h_out_valid), (c >= 3) ? 1 : 0);
            if (c >= 3) check_vec(scen, c - 3);
            if (c < n) drive(c);
            else in_valid = 1'b0;
        end
    endtask

    task automatic test_reset();
        set_all(0, 1234, -777, 1000, 500);
        @(negedge clk);
        drive(0);
        repeat (3) @(negedge clk);
        chk("R2 reset out_valid", int'(out_valid), 0);
        chk("R2 reset y0_re", int'(y0_re), 0);
        chk("R2 reset y3_im", int'(y3_im), 0);
        chk("R2 reset halved y2_im", int'(h_y2_im), 0);
        in_valid = 1'b0;
        rst = 1'b0;
    endtask

    task automatic test_dc();
        set_all(0, 100, -50, 2047, 0);
        set_all(1, -3000, 4000, 0, 2047);
        run_burst("dc R3", 2);
    endtask

    task automatic test_random_burst();
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 4; j++) begin
                vr[k][j] = int'($urandom_range(0, 16000)) - 8000;
                vi[k][j] = int'($urandom_range(0, 16000)) - 8000;
            end
            for (int j = 0; j < 3; j++) begin
                wr[k][j] = int'($urandom_range(0, 4094)) - 2047;
                wi[k][j] = int'($urandom_range(0, 4094)) - 2047;
            end
        end
        run_burst("burst R10", 8);
    endtask

    task automatic test_neg_one();
        set_all(0, 0, 0, -2048, 0);
        vr[0] = '{500, -1200, 37, 9};
        vi[0] = '{-8, 300, 2500, -4444};
        run_burst("negate R6", 1);
    endtask

    task automatic test_floor();
        set_all(0, 0, 0, 16, 0);
        vr[0][0] = 1;  vi[0][0] = -1;
        set_all(1, 0, 0, 0, 16);
        vr[1][0] = -3; vi[1][0] = 3; vr[1][1] = 1;
        run_burst("floor R6", 2);
    endtask

    task automatic test_saturation();
        set_all(0, 32767, 32767, 2047, 0);
        set_all(1, 32767, -32768, -2048, 0);
        vr[1][1] = -32767; vr[1][3] = -32767;
        set_all(2, -32768, -32768, -2048, -2048);
        run_burst("saturate R8", 3);
    endtask

    task automatic test_hold();
        int er[4], ei[4];
        set_all(0, 2100, -900, 1500, -700);
        vr[0][2] = -10;
        run_burst("hold R9", 1);
        model(0, 1'b0, 11, er, ei);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R9 idle y1_re", int'(y1_re), er[1]);
            chk("R9 idle y3_im", int'(y3_im), ei[3]);
            chk("R9 idle out_valid", int'(out_valid), 0);
        end
    endtask

    initial begin
        test_reset();
        test_dc();
        test_random_burst();
        test_neg_one();
        test_floor();
        test_saturation();
        test_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule